// File: doc/BRIEF.md
# Interrupt Steering Aggregator

The block gathers a parameterised number of level-sensitive interrupt lines (a multiple of 32, up to 512) and folds them into one output interrupt per group of 64 lines. Each line first passes a two-flop synchronizer. Three 32-bit register banks control the lines: an enable bank, a software force bank and a read-only status bank. Each line's status is its synchronized level OR its force bit, gated by its enable bit.

A small synchronous register port (byte address, write strobe, write data, combinational read data) programs the block. Through it software sets a one-hot channel selector, the enable and force banks, and a global disable bit. It reads back per-line status and a per-output pending summary.

The banks are stored in reverse: the word at the lowest offset of each bank covers the highest-numbered lines. The spacing between the banks grows with the line count.

Top module: `intsteer_top`

## Requirements
- R1: Every interrupt input is synchronized by two flops, so a change on the input reaches status and outputs after exactly two rising clock edges and not after one.
- R2: Status bit of line n is (synchronized input n OR force bit n) AND enable bit n. An enable bit of 1 passes the line and 0 blocks it. A force bit acts with no synchronizer delay.
- R3: With W = N_IN/32, enable word i is at byte offset 0x4+4i, force word i at 4W+0x4+4i, and status word i at 8W+0x4+4i. Word i covers lines 32(W-1-i) to 32(W-1-i)+31, with bit b being line 32(W-1-i)+b.
- R4: Output k is the OR of the status bits of lines 64k to 64k+63. There are ceil(N_IN/64) outputs, at most 8.
- R5: The channel selector sits at offset 0x0. Outputs can assert only while selector bit CHAN_ID is 1.
- R6: The global disable register sits at 12W+0x4. While its bit 0 is 1, all outputs are low.
- R7: The pending summary at 12W+0x8 has bit k equal to the ungated OR of output k's status bits. The channel selector and the global disable do not affect it.
- R8: Reset clears the selector, enable, force and disable registers, and outputs are low after reset.
- R9: Writes to status offsets are ignored and leave every register unchanged. Reading status has no side effects.
- R10: Reads of any unmapped offset return zero, and writes there have no effect.
- R11: Status follows the input level: it clears two edges after an enabled source drops, when that line's force bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | N_IN | Level-sensitive interrupt sources, asynchronous |
| reg_addr | input | AW | Byte address of register access |
| reg_we | input | 1 | Write strobe, one write per asserted cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_out | output | N_OUT | One interrupt per 64-line group |

## Verification
The bench checks the reversed word order by driving a line in the top word and a line in the bottom word. A design indexing forward would raise the wrong output and show status in the wrong word. It samples one edge after an input change, so a design with one synchronizer stage or none is caught. It also checks that a force bit acts at once, without the synchronizer delay.

The bench confirms that the summary register keeps showing pending groups while the selector or the global disable holds the outputs low. A design that gates the summary would read zero there. Writes aimed at status and at unmapped offsets are followed by read-back of status and enables and by output checks. A decoder that aliases those offsets onto a writable bank would show changed values.

// File: rtl/intsteer_pkg.sv
package intsteer_pkg;
   localparam int WORD_W  = 32;
   localparam int GROUP_W = 64;
   localparam int MAX_OUT = 8;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CHAN,
      RG_EN,
      RG_FORCE,
      RG_STAT,
      RG_GDIS,
      RG_PEND
   } region_e;
endpackage

// File: rtl/intsteer_sync.sv
module intsteer_sync #(
   parameter int W     = 64,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage [DEPTH];

   generate
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage[s] <= '0;
               else        stage[s] <= stage[s-1];
         end
      end
   endgenerate

   assign q = stage[DEPTH-1];
endmodule

// File: rtl/intsteer_regs.sv
module intsteer_regs
   import intsteer_pkg::*;
#(
   parameter int N_IN   = 128,
   parameter int N_OUT  = 2,
   parameter int N_CHAN = 4,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_IN-1:0]   status,
   input  logic [N_OUT-1:0]  pend,
   output logic [N_IN-1:0]   en_q,
   output logic [N_IN-1:0]   force_q,
   output logic [N_CHAN-1:0] chan_q,
   output logic              gdis_q
);
   localparam int WORDS = N_IN / WORD_W;
   localparam int WW    = AW - 2;
   localparam int IW    = (WORDS > 1) ? $clog2(WORDS) : 1;
   localparam logic [WW-1:0] W_EN_HI    = WW'(WORDS);
   localparam logic [WW-1:0] W_FORCE_HI = WW'(2 * WORDS);
   localparam logic [WW-1:0] W_STAT_HI  = WW'(3 * WORDS);
   localparam logic [WW-1:0] W_GDIS     = WW'(3 * WORDS + 1);
   localparam logic [WW-1:0] W_PEND     = WW'(3 * WORDS + 2);

   logic [WW-1:0] word;
   region_e       region;
   logic [IW-1:0] idx;
   int            base;

   assign word = reg_addr[AW-1:2];

   always_comb begin
      region = RG_NONE;
      idx    = '0;
      if (word == '0) begin
         region = RG_CHAN;
      end else if (word <= W_EN_HI) begin
         region = RG_EN;
         idx    = IW'(word - WW'(1));
      end else if (word <= W_FORCE_HI) begin
         region = RG_FORCE;
         idx    = IW'(word - W_EN_HI - WW'(1));
      end else if (word <= W_STAT_HI) begin
         region = RG_STAT;
         idx    = IW'(word - W_FORCE_HI - WW'(1));
      end else if (word == W_GDIS) begin
         region = RG_GDIS;
      end else if (word == W_PEND) begin
         region = RG_PEND;
      end
   end

   // Word 0 of a bank holds the top 32 lines.
   assign base = WORD_W * (WORDS - 1 - int'(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= '0;
         force_q <= '0;
         chan_q  <= '0;
         gdis_q  <= 1'b0;
      end else if (reg_we) begin
         case (region)
            RG_CHAN:  chan_q <= reg_wdata[N_CHAN-1:0];
            RG_EN:    en_q[base +: WORD_W] <= reg_wdata;
            RG_FORCE: force_q[base +: WORD_W] <= reg_wdata;
            RG_GDIS:  gdis_q <= reg_wdata[0];
            default:  ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (region)
         RG_CHAN:  reg_rdata[N_CHAN-1:0] = chan_q;
         RG_EN:    reg_rdata = en_q[base +: WORD_W];
         RG_FORCE: reg_rdata = force_q[base +: WORD_W];
         RG_STAT:  reg_rdata = status[base +: WORD_W];
         RG_GDIS:  reg_rdata[0] = gdis_q;
         RG_PEND:  reg_rdata[N_OUT-1:0] = pend;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/intsteer_combine.sv
module intsteer_combine
   import intsteer_pkg::*;
#(
   parameter int N_IN  = 128,
   parameter int N_OUT = 2
) (
   input  logic [N_IN-1:0]  status,
   input  logic             gate_en,
   output logic [N_OUT-1:0] pend,
   output logic [N_OUT-1:0] irq_out
);
   generate
      for (genvar k = 0; k < N_OUT; k++) begin : g_grp
         localparam int LO = k * GROUP_W;
         localparam int HI = ((k + 1) * GROUP_W > N_IN) ? N_IN - 1 : (k + 1) * GROUP_W - 1;
         assign pend[k]    = |status[HI:LO];
         assign irq_out[k] = pend[k] & gate_en;
      end
   endgenerate
endmodule

// File: rtl/intsteer_top.sv
module intsteer_top
   import intsteer_pkg::*;
#(
   parameter int N_IN       = 128,
   parameter int N_CHAN     = 4,
   parameter int CHAN_ID    = 0,
   parameter int SYNC_DEPTH = 2,
   parameter int AW         = 8,
   localparam int N_OUT     = (N_IN + GROUP_W - 1) / GROUP_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IN-1:0]  irq_in,
   input  logic [AW-1:0]    reg_addr,
   input  logic             reg_we,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   output logic [N_OUT-1:0] irq_out
);
   localparam int WORDS = N_IN / WORD_W;

   generate
      if (N_IN % WORD_W != 0 || N_IN < WORD_W || N_IN > 512) begin : g_bad_n
         $error("N_IN must be a multiple of 32 in 32..512");
      end
      if (N_OUT > MAX_OUT) begin : g_bad_out
         $error("too many outputs");
      end
      if (CHAN_ID >= N_CHAN || N_CHAN > 32) begin : g_bad_chan
         $error("CHAN_ID outside selector");
      end
      if ((12 * WORDS + 12) > (1 << AW)) begin : g_bad_aw
         $error("AW too small for register map");
      end
      if (SYNC_DEPTH < 2) begin : g_bad_sync
         $error("SYNC_DEPTH must be at least 2");
      end
   endgenerate

   logic [N_IN-1:0]   sync_q;
   logic [N_IN-1:0]   en_q;
   logic [N_IN-1:0]   force_q;
   logic [N_IN-1:0]   status;
   logic [N_CHAN-1:0] chan_q;
   logic              gdis_q;
   logic [N_OUT-1:0]  pend;
   logic              gate_en;

   intsteer_sync #(.W(N_IN), .DEPTH(SYNC_DEPTH)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(irq_in), .q(sync_q)
   );

   intsteer_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .N_CHAN(N_CHAN), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .status(status), .pend(pend),
      .en_q(en_q), .force_q(force_q), .chan_q(chan_q), .gdis_q(gdis_q)
   );

   assign status  = (sync_q | force_q) & en_q;
   assign gate_en = chan_q[CHAN_ID] & ~gdis_q;

   intsteer_combine #(.N_IN(N_IN), .N_OUT(N_OUT)) u_comb (
      .status(status), .gate_en(gate_en), .pend(pend), .irq_out(irq_out)
   );
endmodule

// File: rtl/intsteer_chk.sv
module intsteer_chk #(
   parameter int N_IN    = 128,
   parameter int N_OUT   = 2,
   parameter int N_CHAN  = 4,
   parameter int CHAN_ID = 0,
   parameter int AW      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    reg_addr,
   input logic             reg_we,
   input logic [31:0]      reg_wdata,
   input logic [31:0]      reg_rdata,
   input logic [N_OUT-1:0] irq_out,
   input logic [N_OUT-1:0] pend,
   input logic [N_IN-1:0]  en_q,
   input logic [N_IN-1:0]  force_q
);
   localparam int WORDS = N_IN / 32;
   logic [AW-3:0] word;
   logic          at_stat;
   logic          at_void;
   assign word    = reg_addr[AW-1:2];
   assign at_stat = (int'(word) > 2 * WORDS) && (int'(word) <= 3 * WORDS);
   assign at_void = int'(word) > 3 * WORDS + 2;

   a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> irq_out == '0);

   a_r5_channel_off: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && word == '0 && !reg_wdata[CHAN_ID]) |=> irq_out == '0);

   a_r6_global_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(word) == 3 * WORDS + 1 && reg_wdata[0]) |=> irq_out == '0);

   a_r7_out_within_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out & ~pend) == '0);

   a_r9_status_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && at_stat) |=> ($stable(en_q) && $stable(force_q)));

   a_r10_void_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      at_void |-> reg_rdata == '0);
endmodule

bind intsteer_top intsteer_chk #(
   .N_IN(N_IN), .N_OUT(N_OUT), .N_CHAN(N_CHAN), .CHAN_ID(CHAN_ID), .AW(AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out),
   .pend(pend), .en_q(en_q), .force_q(force_q)
);

// File: tb/intsteer_top_bench.sv
module intsteer_top_bench;
   localparam int N_IN  = 128;
   localparam int N_OUT = 2;
   localparam int AW    = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [N_IN-1:0]  irq_in = '0;
   logic [AW-1:0]    reg_addr = '0;
   logic             reg_we = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [N_OUT-1:0] irq_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   intsteer_top #(.N_IN(N_IN), .N_CHAN(4), .CHAN_ID(0), .AW(AW)) u_intsteer_top (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
      .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1 check(req, reg_rdata, exp);
   endtask

   task automatic out_chk(string req, logic [1:0] exp);
      check(req, 32'(irq_out), 32'(exp));
   endtask

   task automatic t_reset;
      out_chk("R8 out after reset", 2'b00);
      rd_chk("R8 selector", 8'h00, 32'h0);
      rd_chk("R8 enable word0", 8'h04, 32'h0);
      rd_chk("R8 force word3", 8'h20, 32'h0);
      rd_chk("R8 global disable", 8'h34, 32'h0);
   endtask

   task automatic t_readback;
      wr(8'h08, 32'hA5A5_0001);
      rd_chk("R3 enable word1 readback", 8'h08, 32'hA5A5_0001);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_sync_and_mask;
      wr(8'h00, 32'h1);
      wr(8'h10, 32'h20);
      @(negedge clk);
      irq_in[5] = 1'b1; irq_in[6] = 1'b1;
      @(negedge clk);
      out_chk("R1 not visible after one edge", 2'b00);
      @(negedge clk);
      out_chk("R1 R4 visible after two edges", 2'b01);
      rd_chk("R2 status word3 masks line 6", 8'h30, 32'h20);
      rd_chk("R7 pending summary", 8'h38, 32'h1);
   endtask

   task automatic t_level;
      @(negedge clk);
      irq_in[5] = 1'b0; irq_in[6] = 1'b0;
      @(negedge clk);
      out_chk("R11 still high one edge after drop", 2'b01);
      @(negedge clk);
      out_chk("R11 low two edges after drop", 2'b00);
      rd_chk("R11 status cleared", 8'h30, 32'h0);
   endtask

   task automatic t_reverse;
      wr(8'h04, 32'h10);
      @(negedge clk);
      irq_in[100] = 1'b1;
      repeat (2) @(negedge clk);
      out_chk("R3 R4 line 100 on output 1", 2'b10);
      rd_chk("R3 line 100 in status word0", 8'h24, 32'h10);
      rd_chk("R3 status word3 empty", 8'h30, 32'h0);
      @(negedge clk);
      irq_in[100] = 1'b0;
      repeat (3) @(negedge clk);
      out_chk("R11 line 100 released", 2'b00);
   endtask

   task automatic t_force;
      wr(8'h18, 32'h40);
      out_chk("R2 force without enable blocked", 2'b00);
      wr(8'h08, 32'h40);
      out_chk("R2 forced line 70 with no sync delay", 2'b10);
      rd_chk("R3 force word1 readback", 8'h18, 32'h40);
      rd_chk("R3 status word1 line 70", 8'h28, 32'h40);
      wr(8'h14, 32'h1);
      rd_chk("R2 forced line 96 blocked by enable", 8'h24, 32'h0);
   endtask

   task automatic t_channel;
      wr(8'h00, 32'h2);
      out_chk("R5 other channel selected", 2'b00);
      rd_chk("R7 summary ungated by selector", 8'h38, 32'h2);
      wr(8'h00, 32'h1);
      out_chk("R5 channel reselected", 2'b10);
   endtask

   task automatic t_gdis;
      wr(8'h34, 32'h1);
      out_chk("R6 disabled", 2'b00);
      rd_chk("R6 disable readback", 8'h34, 32'h1);
      rd_chk("R7 summary ungated by disable", 8'h38, 32'h2);
      wr(8'h34, 32'h0);
      out_chk("R6 re-enabled", 2'b10);
   endtask

   task automatic t_status_write;
      wr(8'h28, 32'hFFFF_FFFF);
      rd_chk("R9 status unchanged", 8'h28, 32'h40);
      rd_chk("R9 status reread", 8'h28, 32'h40);
      rd_chk("R9 enable word1 untouched", 8'h08, 32'h40);
      rd_chk("R9 force word1 untouched", 8'h18, 32'h40);
      out_chk("R9 output unchanged", 2'b10);
   endtask

   task automatic t_unmapped;
      rd_chk("R10 offset 0x3C", 8'h3C, 32'h0);
      rd_chk("R10 offset 0x80", 8'h80, 32'h0);
      wr(8'h3C, 32'hFFFF_FFFF);
      out_chk("R10 void write no effect", 2'b10);
      rd_chk("R10 selector untouched", 8'h00, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_readback();
      t_sync_and_mask();
      t_level();
      t_reverse();
      t_force();
      t_channel();
      t_gdis();
      t_status_write();
      t_unmapped();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule